// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Pin Model

This block is a synthesizable, cycle-based model of a small byte-wide memory that is programmed once. It is driven through the control pins a real device of this kind exposes. A programmer engine or read controller can run against it in simulation or on an emulation fabric and get realistic responses.

Every clock cycle, the block decodes the following inputs into one of seven operating modes:

- chip enable
- output enable
- program strobe
- a flag that says the programming supply is at its high level
- a flag that says an elevated identification voltage is present on address line 9

From that mode it either drives the data output or releases it. Releasing is shown by a low output-enable flag and a zero data value.

Writes can only clear bits. An erase input puts the whole array back to all ones. A program strobe held for fewer than a set number of cycles has no effect, so a verify read shows the old value and the programmer has to retry. Analog levels and access delays are not modelled.

Top module: `eprom_model`

## Requirements
- R1: With chip enable low, output enable low, the supply flag low and the identification flag low, the block drives the stored byte at `addr`. In this case the program strobe has no effect.
- R2: With chip enable high (standby), or with chip enable low and output enable high, `dout_en` is 0 and `dout` is 8'h00.
- R3: With the supply flag high, chip enable low and the program strobe low, the block is in program mode. The outputs are released whatever output enable is, and `din` is taken as write data.
- R4: With the supply flag high, chip enable low, output enable low and the program strobe high, the block drives the stored byte at `addr` (verify).
- R5: With the supply flag high and chip enable high, nothing is written and the outputs are released, even while the program strobe is low.
- R6: With chip enable low, output enable low, the supply flag low and the identification flag high, `dout` is 8'h20 when `addr[0]` is 0 and 8'h61 when `addr[0]` is 1.
- R7: A qualifying program pulse writes the old byte ANDed with `din`. The address and data used are those of the last strobe-low cycle. The write lands at the clock edge that ends the first cycle after program mode is left. A write never turns a 0 into a 1.
- R8: A program pulse of fewer than MIN_PULSE consecutive cycles leaves the array unchanged. MIN_PULSE defaults to 4.
- R9: Reset and `erase` both set every byte to 8'hFF. `erase` also cancels a pulse in progress, so that pulse writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply at high level |
| sig_hi | input | 1 | Identification voltage present on address line 9 |
| addr | input | AW | Byte address, AW = clog2(DEPTH) |
| din | input | 8 | Write data while programming |
| erase | input | 1 | Synchronous erase of the whole array to 8'hFF |
| dout | output | 8 | Read data, 0 when released |
| dout_en | output | 1 | High when the block drives the data bus |

## Verification
The mode decode is tried with a set of pin combinations:

- plain reads
- standby
- output disable
- each identifier byte
- verify
- program with output enable both high and low
- inhibit with the strobe held low

These show whether each mode drives or releases the bus, and whether it returns array data or a fixed code.

The write path is then tried in four ways:

- full-width pulses, including a second pulse on the same byte, which shows AND accumulation against overwrite
- a pulse of MIN_PULSE-1 cycles, which shows the width qualification
- a pulse of all-ones data, which shows that cleared bits are never set again
- an erase during a pulse, which shows that erase cancels the pending write

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY   = 3'd0,
    MD_INHIBIT   = 3'd1,
    MD_OUTDIS    = 3'd2,
    MD_READ      = 3'd3,
    MD_SIGNATURE = 3'd4,
    MD_PROGRAM   = 3'd5,
    MD_VERIFY    = 3'd6
  } mode_e;

  localparam logic [7:0] ID_MAKER = 8'h20;
  localparam logic [7:0] ID_PART  = 8'h61;
  localparam logic [7:0] BLANK    = 8'hFF;

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  pgm_n,
  input  logic  vpp_hi,
  input  logic  sig_hi,
  output mode_e mode
);

  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
    end else if (vpp_hi) begin
      if (!pgm_n)     mode = MD_PROGRAM;
      else if (!oe_n) mode = MD_VERIFY;
      else            mode = MD_OUTDIS;
    end else if (oe_n) begin
      mode = MD_OUTDIS;
    end else begin
      mode = sig_hi ? MD_SIGNATURE : MD_READ;
    end
  end

endmodule

// File: rtl/eprom_pulse_qual.sv
module eprom_pulse_qual #(
  parameter int AW        = 6,
  parameter int MIN_PULSE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase,
  input  logic          prog_on,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [7:0]    commit_data
);

  localparam int CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] WSAT = CW'(MIN_PULSE);

  logic          active_q, active_d;
  logic [CW-1:0] width_q, width_d;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          cap_en;

  always_comb begin
    active_d = 1'b0;
    width_d  = '0;
    cap_en   = 1'b0;
    if (!erase && prog_on) begin
      active_d = 1'b1;
      width_d  = (width_q == WSAT) ? WSAT : width_q + 1'b1;
      cap_en   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      width_q  <= '0;
    end else begin
      active_q <= active_d;
      width_q  <= width_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= addr;
      data_q <= din;
    end
  end

  assign commit      = active_q && !prog_on && !erase && (width_q >= WSAT);
  assign commit_addr = addr_q;
  assign commit_data = data_q;

  // R7: a write only follows the end of a strobe
  a_r7_commit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!prog_on && $past(prog_on)));

  // R9: erase leaves nothing pending
  a_r9_erase_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> !commit);

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
  import eprom_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem_q [DEPTH];
  logic [7:0] mem_d [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (erase)
        mem_d[i] = BLANK;
      else if (wr_en && (int'(wr_addr) == i))
        mem_d[i] = mem_q[i] & wr_data;
      else
        mem_d[i] = mem_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= BLANK;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_data = (int'(rd_addr) < DEPTH) ? mem_q[rd_addr] : BLANK;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell_chk
      // R7: without erase, no bit may go from 0 to 1
      a_r7_bits_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !erase |=> ((mem_q[g] & ~$past(mem_q[g])) == 8'h00));
      // R9: erase fills every byte
      a_r9_erase_fill: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (mem_q[g] == BLANK));
    end
  endgenerate

endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter  int DEPTH     = 64,
  parameter  int MIN_PULSE = 4,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          pgm_n,
  input  logic          vpp_hi,
  input  logic          sig_hi,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          erase,
  output logic [7:0]    dout,
  output logic          dout_en
);

  mode_e         mode;
  logic          commit;
  logic [AW-1:0] commit_addr;
  logic [7:0]    commit_data;
  logic [7:0]    cell_byte;

  eprom_mode_dec u_dec (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .pgm_n  (pgm_n),
    .vpp_hi (vpp_hi),
    .sig_hi (sig_hi),
    .mode   (mode)
  );

  eprom_pulse_qual #(.AW(AW), .MIN_PULSE(MIN_PULSE)) u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .erase       (erase),
    .prog_on     (mode == MD_PROGRAM),
    .addr        (addr),
    .din         (din),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_data (commit_data)
  );

  eprom_cell_array #(.DEPTH(DEPTH), .AW(AW)) u_cells (
    .clk     (clk),
    .rst_n   (rst_n),
    .erase   (erase),
    .wr_en   (commit),
    .wr_addr (commit_addr),
    .wr_data (commit_data),
    .rd_addr (addr),
    .rd_data (cell_byte)
  );

  always_comb begin
    dout    = 8'h00;
    dout_en = 1'b0;
    unique case (mode)
      MD_READ, MD_VERIFY: begin
        dout    = cell_byte;
        dout_en = 1'b1;
      end
      MD_SIGNATURE: begin
        dout    = addr[0] ? ID_PART : ID_MAKER;
        dout_en = 1'b1;
      end
      default: begin
        dout    = 8'h00;
        dout_en = 1'b0;
      end
    endcase
  end

  // R2: a deselected device never drives
  a_r2_standby_float: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dout_en && dout == 8'h00));
  // R3: the bus is an input while the strobe is low under high supply
  a_r3_program_float: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && !ce_n && !pgm_n) |-> !dout_en);
  // R6: identifier bytes
  a_r6_sig_maker: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi && sig_hi && !addr[0]) |-> (dout_en && dout == ID_MAKER));
  a_r6_sig_part: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi && sig_hi && addr[0]) |-> (dout_en && dout == ID_PART));
  // R1: a held read address gives steady data when nothing is written
  a_r1_read_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MD_READ && mode == MD_READ && $stable(addr)
     && !$past(erase) && !$past(commit)) |-> $stable(dout));

endmodule

// File: tb/sim_eprom_model.sv
`timescale 1ns/1ps
module sim_eprom_model;

  localparam int DEPTH = 64;
  localparam int MINP  = 4;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, pgm_n, vpp_hi, sig_hi, erase;
  logic [AW-1:0] addr;
  logic [7:0]    din;
  logic [7:0]    dout;
  logic          dout_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] ref_mem [DEPTH];
  bit         ref_active;
  int         ref_width;
  int         ref_ca;
  logic [7:0] ref_cd;

  always #4 clk = ~clk;

  eprom_model #(.DEPTH(DEPTH), .MIN_PULSE(MINP)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .sig_hi(sig_hi), .addr(addr), .din(din), .erase(erase),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic ref_clear();
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    ref_active = 0;
    ref_width  = 0;
  endtask

  task automatic expect_now(output bit en, output logic [7:0] val, output string tag);
    en = 0; val = 8'h00; tag = "R2";
    if (ce_n) begin
      tag = vpp_hi ? "R5" : "R2";
    end else if (vpp_hi) begin
      if (!pgm_n)     tag = "R3";
      else if (!oe_n) begin en = 1; val = ref_mem[addr]; tag = "R4"; end
    end else if (!oe_n) begin
      en = 1;
      if (sig_hi) begin val = addr[0] ? 8'h61 : 8'h20; tag = "R6"; end
      else begin val = ref_mem[addr]; tag = "R1"; end
    end
  endtask

  task automatic ref_clock();
    bit prog;
    prog = vpp_hi && !ce_n && !pgm_n;
    if (erase) begin
      ref_clear();
    end else if (prog) begin
      ref_active = 1;
      if (ref_width < MINP) ref_width++;
      ref_ca = int'(addr);
      ref_cd = din;
    end else begin
      if (ref_active && ref_width >= MINP) ref_mem[ref_ca] = ref_mem[ref_ca] & ref_cd;
      ref_active = 0;
      ref_width  = 0;
    end
  endtask

  // one cycle: drive at the falling edge, compare mid-phase, update the model at the rising edge
  task automatic cyc(input logic c, input logic o, input logic p, input logic v,
                     input logic s, input int a, input logic [7:0] d,
                     input logic e, input string why);
    bit         xen;
    logic [7:0] xv;
    string      tg;
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; sig_hi = s;
    addr = AW'(a); din = d; erase = e;
    #2;
    expect_now(xen, xv, tg);
    if (why != "") tg = why;
    n_cmp++;
    if (dout_en !== xen || dout !== xv) begin
      n_bad++;
      $display("FAIL %s t=%0t addr=%0d: actual en=%0b dout=%02h expected en=%0b dout=%02h",
               tg, $time, a, dout_en, dout, xen, xv);
    end
    @(posedge clk);
    ref_clock();
    @(negedge clk);
  endtask

  task automatic rd(input int a, input string why);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, 8'h00, 1'b0, why);
  endtask

  task automatic pulse(input int a, input logic [7:0] d, input int n, input logic o, input string why);
    for (int k = 0; k < n; k++) cyc(1'b0, o, 1'b0, 1'b1, 1'b0, a, d, 1'b0, why);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, a, 8'h00, 1'b0, why); // strobe released, verify
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, a, 8'h00, 1'b0, why); // verify after the write lands
  endtask

  initial begin
    rst_n = 1'b0;
    ce_n = 1; oe_n = 1; pgm_n = 1; vpp_hi = 0; sig_hi = 0; erase = 0;
    addr = '0; din = '0;
    ref_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state: all bytes blank
    for (int i = 0; i < 8; i++) rd(i * 9, "R9");
    // R1: reads with the strobe low and supply low
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 17, 8'h00, 1'b0, "R1");
    // R2: standby and output disable
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3, 8'h00, 1'b0, "R2");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3, 8'h00, 1'b0, "R2");
    // R6: identifier bytes, other address bits set
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'h2A, 8'h00, 1'b0, "R6");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 6'h2B, 8'h00, 1'b0, "R6");
    // R7: full pulse, then accumulate on the same byte
    pulse(3, 8'hA5, MINP, 1'b1, "R7");
    rd(3, "R7");
    pulse(3, 8'h3C, MINP + 2, 1'b1, "R7");
    rd(3, "R7");
    // R7: all-ones data restores nothing
    pulse(3, 8'hFF, MINP, 1'b1, "R7");
    rd(3, "R7");
    // R3: output enable low during program has no effect on the write
    pulse(40, 8'h0F, MINP, 1'b0, "R3");
    rd(40, "R3");
    // R8: short pulse leaves the byte blank
    pulse(5, 8'h00, MINP - 1, 1'b1, "R8");
    rd(5, "R8");
    // R5: inhibit with the strobe low
    for (int k = 0; k < MINP + 1; k++) cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9, 8'h00, 1'b0, "R5");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9, 8'h00, 1'b0, "R5");
    rd(9, "R5");
    // R4: verify with the identification flag up shows array data, not a code
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 40, 8'h00, 1'b0, "R4");
    // R9: erase clears written bytes
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 0, 8'h00, 1'b1, "R9");
    rd(3, "R9");
    rd(40, "R9");
    // R9: erase during a pulse cancels it
    for (int k = 0; k < MINP; k++) cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12, 8'h00, 1'b0, "R9");
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12, 8'h00, 1'b1, "R9");
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12, 8'h00, 1'b0, "R9");
    rd(12, "R9");
    // mixed sweep over several addresses
    for (int i = 0; i < 6; i++) begin
      pulse(20 + i, 8'(8'hF0 >> i), MINP + (i % 2), 1'b1, "R7");
      rd(20 + i, "R1");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual run incomplete expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule